// File: doc/BRIEF.md
# Fault Injection Check-Mode Sequencer

This block times a host-driven check request that forces every fault monitor of a sensor into its fault condition. Detection and reporting can then both be exercised end to end. While the request is held, the block drives an injection enable to each monitor that the `INJ_MASK` parameter selects. It also drives a fixed offset for the self-test amplitude path that pushes the measured amplitude past its fault limit. Finally, it raises an override that forces the status code of every data response to the self-test value 0b10.

All timing runs on a millisecond timebase tick. A settle window of `SETTLE_MS` ticks follows the request. When it ends, `faults_due` tells the host that every injected fault is now guaranteed to be visible in the fault register. After the request drops, a decay window of `DECAY_MS` ticks keeps `normal_ready` low while the injected faults die away.

The state machine has four states:
- `SQ_IDLE`: normal operation.
- `SQ_SETTLE`: injecting and timing the settle window.
- `SQ_HOLD`: injecting, with faults guaranteed visible.
- `SQ_DECAY`: injection off, timing the decay window.

The transitions are:
- IDLE→SETTLE when the request is sampled high.
- SETTLE→HOLD on the last settle tick.
- SETTLE→DECAY and HOLD→DECAY when the request is sampled low.
- DECAY→SETTLE when the request is sampled high again.
- DECAY→IDLE on the last decay tick.

Top module: `chk_inject_seq`

## Requirements
- R1: After reset the block is idle: `inj_en` = 0, `st_ofs` = 0, `chk_active` = 0, `faults_due` = 0, `normal_ready` = 1.
- R2: When `chk_req` is sampled high in idle, all bits of `inj_en` set by `INJ_MASK` go to 1 together in the next cycle, and the other bits stay 0. `chk_active` goes to 1 and `normal_ready` goes to 0 in that same cycle.
- R3: `faults_due` goes high in the cycle after the clock edge that samples the `SETTLE_MS`-th `ms_tick` since entry to settle. It stays high while `chk_req` stays high.
- R4: `chk_active` (status forced to 0b10) is 1 exactly while the block is injecting. It goes to 0 in the cycle after `chk_req` is sampled low.
- R5: `st_ofs` equals `ST_LIMIT + ST_MARGIN` whenever `chk_active` is 1, and 0 otherwise.
- R6: After `chk_req` is sampled low, `inj_en`, `chk_active` and `faults_due` are 0. `normal_ready` stays 0 until the edge that samples the `DECAY_MS`-th `ms_tick` of the decay window, and is 1 in the following cycle.
- R7: When `chk_req` is sampled high during decay, the block returns to settle and injects again. The settle count restarts from zero, so `SETTLE_MS` new ticks are needed before `faults_due` rises.
- R8: When `chk_req` is sampled low during settle, the block enters decay with a fresh count, and `faults_due` never rises.
- R9: `ms_tick` has no effect in idle or hold. Ticks seen there neither change the outputs nor shorten a later settle or decay window.
- R10: When a request change and a window's final tick fall in the same cycle, the request wins. In decay, a high request goes to settle rather than idle. In settle, a low request goes to decay rather than hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_req | input | 1 | Host check request |
| ms_tick | input | 1 | One-cycle millisecond timebase pulse |
| inj_en | output | N_FAULT | Per-monitor fault injection enables |
| st_ofs | output | OFS_W | Offset added to the measured self-test amplitude |
| chk_active | output | 1 | Status override: response status reads 0b10 |
| faults_due | output | 1 | Settle window elapsed; all injected faults visible |
| normal_ready | output | 1 | Normal operation; no injection or decay in progress |

## Verification
The two functions that can meet in one cycle are window expiry and the response to a change of the request. Both the final `ms_tick` of a window and a request edge can be sampled by the same clock edge.

The bench steers the block into each window, counts ticks until one tick remains, and then drives the last tick together with the opposite request level. This is done once with a rising request at the end of decay and once with a falling request at the end of settle. The bench judges the outcome by the outputs of the next cycle. Injection and `chk_active` must come back in the first case. In the second, `faults_due` must stay low while `normal_ready` also stays low. A behavioural reference model compares every output on every clock throughout.

// File: rtl/chkseq_pkg.sv
package chkseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_HOLD   = 2'd2,
        SQ_DECAY  = 2'd3
    } sq_state_e;

endpackage

// File: rtl/chkseq_timer.sv
module chkseq_timer #(
    parameter int unsigned SETTLE_MS = 50,
    parameter int unsigned DECAY_MS  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic sel_decay,
    input  logic tick,
    output logic win_done
);
    localparam int unsigned TOP_MS = (SETTLE_MS > DECAY_MS) ? SETTLE_MS : DECAY_MS;
    localparam int unsigned CNT_W  = (TOP_MS < 2) ? 1 : $clog2(TOP_MS);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SETTLE_MS - 1);
    localparam logic [CNT_W-1:0] LIM_D = CNT_W'(DECAY_MS - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim      = sel_decay ? LIM_D : LIM_S;
    assign win_done = run && tick && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the count never passes the limit of the window being timed
    p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim));

    // R9: outside a timed window the count does not move
    p_tick_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/chkseq_fsm.sv
module chkseq_fsm
    import chkseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chk_req,
    input  logic      win_done,
    output sq_state_e state,
    output logic      tmr_clr,
    output logic      tmr_run,
    output logic      sel_decay
);
    sq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:   if (chk_req)       nxt = SQ_SETTLE;
            SQ_SETTLE: if (!chk_req)      nxt = SQ_DECAY;
                       else if (win_done) nxt = SQ_HOLD;
            SQ_HOLD:   if (!chk_req)      nxt = SQ_DECAY;
            SQ_DECAY:  if (chk_req)       nxt = SQ_SETTLE;
                       else if (win_done) nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        tmr_clr   = (nxt != state);
        tmr_run   = (state == SQ_SETTLE) || (state == SQ_DECAY);
        sel_decay = (state == SQ_DECAY);
    end

    // R2: a request seen in idle always starts the settle window
    p_enter_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && chk_req) |=> (state == SQ_SETTLE));

    // R7 / R10: a request during decay always re-enters settle
    p_reenter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DECAY && chk_req) |=> (state == SQ_SETTLE));

    // R8: a drop during settle never reaches hold
    p_settle_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SETTLE && !chk_req) |=> (state == SQ_DECAY));

endmodule

// File: rtl/chkseq_drive.sv
module chkseq_drive
    import chkseq_pkg::*;
#(
    parameter int unsigned          N_FAULT   = 10,
    parameter logic [N_FAULT-1:0]   INJ_MASK  = '1,
    parameter int unsigned          OFS_W     = 12,
    parameter int unsigned          ST_LIMIT  = 512,
    parameter int unsigned          ST_MARGIN = 256
) (
    input  sq_state_e          state,
    output logic [N_FAULT-1:0] inj_en,
    output logic [OFS_W-1:0]   st_ofs,
    output logic               chk_active,
    output logic               faults_due,
    output logic               normal_ready
);
    localparam logic [OFS_W-1:0] OFS_VAL = OFS_W'(ST_LIMIT + ST_MARGIN);

    logic inj_on;

    always_comb begin
        inj_on       = 1'b0;
        faults_due   = 1'b0;
        normal_ready = 1'b0;
        unique case (state)
            SQ_IDLE:   normal_ready = 1'b1;
            SQ_SETTLE: inj_on       = 1'b1;
            SQ_HOLD: begin
                inj_on     = 1'b1;
                faults_due = 1'b1;
            end
            SQ_DECAY:  ;
        endcase
    end

    assign chk_active = inj_on;
    assign st_ofs     = inj_on ? OFS_VAL : '0;

    for (genvar i = 0; i < int'(N_FAULT); i++) begin : g_inj
        if (INJ_MASK[i]) begin : g_on
            assign inj_en[i] = inj_on;
        end else begin : g_off
            assign inj_en[i] = 1'b0;
        end
    end

endmodule

// File: rtl/chk_inject_seq.sv
module chk_inject_seq
    import chkseq_pkg::*;
#(
    parameter int unsigned        N_FAULT   = 10,
    parameter logic [N_FAULT-1:0] INJ_MASK  = '1,
    parameter int unsigned        SETTLE_MS = 50,
    parameter int unsigned        DECAY_MS  = 50,
    parameter int unsigned        OFS_W     = 12,
    parameter int unsigned        ST_LIMIT  = 512,
    parameter int unsigned        ST_MARGIN = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_req,
    input  logic               ms_tick,
    output logic [N_FAULT-1:0] inj_en,
    output logic [OFS_W-1:0]   st_ofs,
    output logic               chk_active,
    output logic               faults_due,
    output logic               normal_ready
);
    sq_state_e state;
    logic      tmr_clr;
    logic      tmr_run;
    logic      sel_decay;
    logic      win_done;

    chkseq_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_req   (chk_req),
        .win_done  (win_done),
        .state     (state),
        .tmr_clr   (tmr_clr),
        .tmr_run   (tmr_run),
        .sel_decay (sel_decay)
    );

    chkseq_timer #(
        .SETTLE_MS (SETTLE_MS),
        .DECAY_MS  (DECAY_MS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tmr_clr),
        .run       (tmr_run),
        .sel_decay (sel_decay),
        .tick      (ms_tick),
        .win_done  (win_done)
    );

    chkseq_drive #(
        .N_FAULT   (N_FAULT),
        .INJ_MASK  (INJ_MASK),
        .OFS_W     (OFS_W),
        .ST_LIMIT  (ST_LIMIT),
        .ST_MARGIN (ST_MARGIN)
    ) i_drive (
        .state        (state),
        .inj_en       (inj_en),
        .st_ofs       (st_ofs),
        .chk_active   (chk_active),
        .faults_due   (faults_due),
        .normal_ready (normal_ready)
    );

    // R2: no monitor is ever injected without the status override
    p_inj_needs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en != '0) |-> chk_active);

    // R4: a dropped request removes the override in the next cycle
    p_override_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_active && !chk_req) |=> !chk_active);

    // R3: faults are only declared due while injecting
    p_due_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        faults_due |-> chk_active);

    // R5: the amplitude offset appears only under the override
    p_ofs_with_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ofs != '0) |-> chk_active);

    // R6: ready excludes any injection or override
    p_ready_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        normal_ready |-> (!chk_active && (inj_en == '0)));

endmodule

// File: tb/test_chk_inject_seq.sv
module test_chk_inject_seq;

    localparam int          CLK_PERIOD = 10;
    localparam int          N_FAULT    = 10;
    localparam logic [9:0]  MASK       = 10'h2F7;
    localparam int          SETTLE     = 50;
    localparam int          DECAY      = 50;
    localparam int          OFS_W      = 12;
    localparam int          LIM        = 512;
    localparam int          MARGIN     = 256;
    localparam int          WATCHDOG   = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               chk_req = 1'b0;
    logic               ms_tick = 1'b0;
    logic [N_FAULT-1:0] inj_en;
    logic [OFS_W-1:0]   st_ofs;
    logic               chk_active;
    logic               faults_due;
    logic               normal_ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // reference model: 0 idle, 1 settle, 2 hold, 3 decay
    int m_st  = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chk_inject_seq #(
        .N_FAULT   (N_FAULT),
        .INJ_MASK  (MASK),
        .SETTLE_MS (SETTLE),
        .DECAY_MS  (DECAY),
        .OFS_W     (OFS_W),
        .ST_LIMIT  (LIM),
        .ST_MARGIN (MARGIN)
    ) i_chk_inject_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_req      (chk_req),
        .ms_tick      (ms_tick),
        .inj_en       (inj_en),
        .st_ofs       (st_ofs),
        .chk_active   (chk_active),
        .faults_due   (faults_due),
        .normal_ready (normal_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: if (chk_req) begin m_st = 1; m_cnt = 0; end
                1: if (!chk_req) begin m_st = 3; m_cnt = 0; end
                   else if (ms_tick) begin
                       m_cnt++;
                       if (m_cnt == SETTLE) begin m_st = 2; m_cnt = 0; end
                   end
                2: if (!chk_req) begin m_st = 3; m_cnt = 0; end
                default: if (chk_req) begin m_st = 1; m_cnt = 0; end
                   else if (ms_tick) begin
                       m_cnt++;
                       if (m_cnt == DECAY) begin m_st = 0; m_cnt = 0; end
                   end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            automatic bit inj = (m_st == 1) || (m_st == 2);
            automatic int e_inj = inj ? int'(MASK) : 0;
            automatic int e_ofs = inj ? (LIM + MARGIN) : 0;
            chk(int'(inj_en) == e_inj, "R2 model inj_en", int'(inj_en), e_inj);
            chk(chk_active == inj, "R4 model chk_active", int'(chk_active), int'(inj));
            chk(int'(st_ofs) == e_ofs, "R5 model st_ofs", int'(st_ofs), e_ofs);
            chk(faults_due == (m_st == 2), "R3 model faults_due", int'(faults_due), int'(m_st == 2));
            chk(normal_ready == (m_st == 0), "R6 model normal_ready", int'(normal_ready), int'(m_st == 0));
        end
    end

    task automatic step(input logic r, input logic t);
        @(negedge clk);
        chk_req = r;
        ms_tick = t;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    // n ticks, each followed by a quiet cycle, request held at r
    task automatic ticks(input logic r, input int n);
        for (int k = 0; k < n; k++) begin
            step(r, 1'b1);
            step(r, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(inj_en) == 0 && st_ofs == 0 && !chk_active && !faults_due && normal_ready,
            "R1 reset state", int'(normal_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: ticks in idle
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1);
        chk(normal_ready && !chk_active, "R9 idle ticks", int'(normal_ready), 1);

        // R2 / R5: entry
        step(1'b1, 1'b0);
        chk(int'(inj_en) == int'(MASK), "R2 inj_en on entry", int'(inj_en), int'(MASK));
        chk(chk_active && !normal_ready, "R2 override on entry", int'(chk_active), 1);
        chk(int'(st_ofs) == LIM + MARGIN, "R5 offset value", int'(st_ofs), LIM + MARGIN);

        // R3: settle window length
        ticks(1'b1, SETTLE - 1);
        chk(!faults_due, "R3 due before last tick", int'(faults_due), 0);
        step(1'b1, 1'b1);
        chk(faults_due, "R3 due after last tick", int'(faults_due), 1);

        // R9: ticks in hold
        ticks(1'b1, 30);
        chk(faults_due && chk_active, "R9 hold ticks", int'(faults_due), 1);

        // R4 / R6: release and decay
        step(1'b0, 1'b0);
        chk(!chk_active && inj_en == '0 && !faults_due, "R4 override drop", int'(chk_active), 0);
        chk(st_ofs == '0, "R5 offset removed", int'(st_ofs), 0);
        ticks(1'b0, DECAY - 1);
        chk(!normal_ready, "R6 ready before last tick", int'(normal_ready), 0);
        step(1'b0, 1'b1);
        chk(normal_ready, "R6 ready after decay", int'(normal_ready), 1);

        // R8: drop during settle
        step(1'b1, 1'b0);
        ticks(1'b1, 10);
        step(1'b0, 1'b0);
        chk(!chk_active && !faults_due && !normal_ready, "R8 settle drop", int'(chk_active), 0);
        ticks(1'b0, 20);

        // R7: re-assert during decay, settle restarts
        step(1'b1, 1'b0);
        chk(chk_active && int'(inj_en) == int'(MASK), "R7 reenter settle", int'(chk_active), 1);
        ticks(1'b1, SETTLE - 1);
        chk(!faults_due, "R7 settle restarted", int'(faults_due), 0);
        step(1'b1, 1'b1);
        chk(faults_due, "R7 due after full settle", int'(faults_due), 1);

        // R10: final decay tick with rising request
        step(1'b0, 1'b0);
        ticks(1'b0, DECAY - 1);
        step(1'b1, 1'b1);
        chk(chk_active && !normal_ready, "R10 decay collision", int'(chk_active), 1);

        // R10: final settle tick with falling request
        ticks(1'b1, SETTLE - 1);
        step(1'b0, 1'b1);
        chk(!faults_due && !chk_active && !normal_ready, "R10 settle collision", int'(faults_due), 0);
        ticks(1'b0, DECAY);
        chk(normal_ready, "R6 ready after collision decay", int'(normal_ready), 1);

        // mixed traffic against the model
        for (int k = 0; k < 20000; k++) begin
            automatic int rv = int'($urandom_range(0, 99));
            automatic logic r = (rv < 3) ? ~chk_req : chk_req;
            step(r, ($urandom_range(0, 3) == 0));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule